// File: doc/BRIEF.md
# Selectable Audio Delay Line

This block delays a one-bit audio stream, as produced by a delta modulator, by one of six selectable lengths. A single on-chip memory serves as a circular buffer. Each accepted sample strobe writes the incoming bit at the write pointer. On the same clock edge, the block reads back the bit stored a chosen number of samples earlier and drives it on the registered output. A 3-bit code picks a delay of one to six steps. Each step is `SAMPLES_PER_STEP` sample periods.

A speed select halves the effective sample rate. In slow mode the block takes only every second strobe, so the same code spans twice the time. This gives 20 to 120 ms steps instead of 10 to 60 ms when one step is 10 ms of fast-mode samples.

Holding mute silences the output and starts a sweep that writes zero to every memory location, one location per clock. When the sweep completes, the block raises a flag. Releasing mute after that flag restarts the stream from address zero on a blank buffer, so old audio never plays after a change of delay or speed. The memory depth defaults to a small value for elaboration and is set to 12288 one-bit samples in the target.

Top module: `audio_delay_line`

## Requirements
- R1: While `rst` is high, `sample_out` and `clear_done` are 0 on the following clock.
- R2: In fast mode (`slow_mode`=0), every strobe is accepted. With a valid code c (0 to 5), the output after accepted strobe n equals the input of accepted strobe n-(c+1)*SAMPLES_PER_STEP. It is valid from the clock edge that samples the strobe.
- R3: In slow mode (`slow_mode`=1), counting strobes from the release of mute starting at zero, only even-numbered strobes are accepted and odd-numbered strobes leave `sample_out` unchanged. The delay in input strobes is therefore doubled.
- R4: Codes 3'b110 and 3'b111 are reserved and leave the previously selected delay in force.
- R5: On every clock edge that samples `mute` high, `sample_out` becomes 0, and strobes during mute are not accepted.
- R6: `clear_done` rises on the DEPTH-th clock edge that samples `mute` high, stays high while `mute` stays high, and returns to 0 on the first edge that samples `mute` low.
- R7: After a complete clear and release of mute, the first (c+1)*SAMPLES_PER_STEP accepted strobes output 0, whatever the buffer held before.
- R8: The read position wraps modulo DEPTH, so the delay stays exact after more than DEPTH accepted strobes.
- R9: On a clock edge with no strobe and `mute` low, `sample_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| sample_in | input | 1 | Input audio bit |
| delay_code | input | 3 | Delay step select, 0 to 5 valid |
| slow_mode | input | 1 | 1: accept every second strobe |
| mute | input | 1 | Silence output and clear the buffer |
| sample_out | output | 1 | Delayed audio bit, registered |
| clear_done | output | 1 | Buffer sweep complete while muted |

## Verification
The assertions assume three things about how the block is used:
- `mute` is held until `clear_done` rises.
- `delay_code` and `slow_mode` change only while muted.
- Strobes last exactly one clock.

The stimulus follows these rules. It applies every new code and speed inside a full clear. It holds mute for DEPTH plus two clocks. It separates single-cycle strobes with idle clocks, so the hold behaviour between strobes is observed on every sample.

// File: rtl/adl_pkg.sv
package adl_pkg;
  localparam int unsigned NUM_STEPS = 6;

  typedef logic [2:0] dly_code_t;

  function automatic logic code_is_valid(input dly_code_t c);
    return (c < 3'(NUM_STEPS));
  endfunction
endpackage

// File: rtl/adl_delay_decode.sv
module adl_delay_decode
  import adl_pkg::*;
#(
  parameter int unsigned SAMPLES_PER_STEP = 256,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  dly_code_t     code,
  output dly_code_t     sel,
  output logic [AW-1:0] delay_samples
);
  // Selected step index; reserved codes do not update it.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (code_is_valid(code)) begin
      sel <= code;
    end
  end

  assign delay_samples = AW'((int'(sel) + 1) * SAMPLES_PER_STEP);
endmodule

// File: rtl/adl_clear_engine.sv
module adl_clear_engine #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mute,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr,
  output logic          clear_done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || !mute) begin
      clr_addr   <= '0;
      clear_done <= 1'b0;
    end else if (!clear_done) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == LAST) begin
        clear_done <= 1'b1;
      end
    end
  end

  assign clr_we = mute && !clear_done;
endmodule

// File: rtl/adl_ring_mem.sv
module adl_ring_mem #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          rd_clr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read port with synchronous output clear.
  always_ff @(posedge clk) begin
    if (rd_clr) begin
      rdata <= 1'b0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line
  import adl_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned SAMPLES_PER_STEP = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_stb,
  input  logic       sample_in,
  input  logic [2:0] delay_code,
  input  logic       slow_mode,
  input  logic       mute,
  output logic       sample_out,
  output logic       clear_done
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] WR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0] DEPTH_W = (AW + 1)'(DEPTH);

  if (NUM_STEPS * SAMPLES_PER_STEP >= DEPTH) begin : g_depth_check
    $error("longest delay must be shorter than the buffer depth");
  end

  dly_code_t     delay_sel;
  logic [AW-1:0] delay_samples;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [AW:0]   rd_wide;
  logic          phase;
  logic          take;
  logic          clr_we;
  logic [AW-1:0] clr_addr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic          mem_wdata;

  adl_delay_decode #(
    .SAMPLES_PER_STEP(SAMPLES_PER_STEP),
    .AW(AW)
  ) u_dec (
    .clk(clk),
    .rst(rst),
    .code(delay_code),
    .sel(delay_sel),
    .delay_samples(delay_samples)
  );

  adl_clear_engine #(
    .DEPTH(DEPTH),
    .AW(AW)
  ) u_clr (
    .clk(clk),
    .rst(rst),
    .mute(mute),
    .clr_we(clr_we),
    .clr_addr(clr_addr),
    .clear_done(clear_done)
  );

  // Slow mode accepts the first strobe after release, then every second one.
  assign take = sample_stb && !mute && (!slow_mode || !phase);

  always_ff @(posedge clk) begin
    if (rst || mute) begin
      wr_ptr <= '0;
      phase  <= 1'b0;
    end else if (sample_stb) begin
      phase <= slow_mode ? ~phase : 1'b0;
      if (take) begin
        wr_ptr <= (wr_ptr == WR_LAST) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

  // Read address = write address - delay, modulo DEPTH.
  always_comb begin
    rd_wide = {1'b0, wr_ptr} - {1'b0, delay_samples};
    if (wr_ptr < delay_samples) begin
      rd_wide = rd_wide + DEPTH_W;
    end
    rd_addr = rd_wide[AW-1:0];
  end

  assign mem_we    = clr_we || take;
  assign mem_waddr = clr_we ? clr_addr : wr_ptr;
  assign mem_wdata = clr_we ? 1'b0 : sample_in;

  adl_ring_mem #(
    .DEPTH(DEPTH),
    .AW(AW)
  ) u_mem (
    .clk(clk),
    .we(mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re(take),
    .raddr(rd_addr),
    .rd_clr(rst || mute),
    .rdata(sample_out)
  );
endmodule

// File: rtl/adl_checker.sv
module adl_checker (
  input logic       clk,
  input logic       rst,
  input logic       sample_stb,
  input logic [2:0] delay_code,
  input logic       mute,
  input logic       sample_out,
  input logic       clear_done,
  input logic [2:0] delay_sel
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!sample_out && !clear_done));

  assert_reserved_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (delay_code > 3'd5) |=> $stable(delay_sel));

  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (rst)
    mute |=> !sample_out);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mute && clear_done) |=> clear_done);

  assert_done_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !mute |=> !clear_done);

  assert_done_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(clear_done) |-> $past(mute));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !mute) |=> $stable(sample_out));
endmodule

bind audio_delay_line adl_checker u_chk (
  .clk(clk),
  .rst(rst),
  .sample_stb(sample_stb),
  .delay_code(delay_code),
  .mute(mute),
  .sample_out(sample_out),
  .clear_done(clear_done),
  .delay_sel(delay_sel)
);

// File: tb/sim_audio_delay_line.sv
`timescale 1ns/1ps
module sim_audio_delay_line;
  localparam int DEPTH = 64;
  localparam int SPS   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_stb = 1'b0;
  logic sample_in = 1'b0;
  logic [2:0] delay_code = 3'd0;
  logic slow_mode = 1'b0;
  logic mute = 1'b0;
  logic sample_out;
  logic clear_done;

  int checks = 0;
  int errors = 0;
  bit hist [0:255];

  always #10 clk = ~clk;

  audio_delay_line #(.DEPTH(DEPTH), .SAMPLES_PER_STEP(SPS)) u0 (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_in(sample_in),
    .delay_code(delay_code), .slow_mode(slow_mode), .mute(mute),
    .sample_out(sample_out), .clear_done(clear_done)
  );

  // Row: slow, code, input strobes, seed
  localparam logic [19:0] ROWS [0:7] = '{
    {1'b0, 3'd0, 8'd60,  8'h5A},
    {1'b0, 3'd1, 8'd60,  8'h33},
    {1'b0, 3'd2, 8'd70,  8'hC7},
    {1'b0, 3'd3, 8'd80,  8'h19},
    {1'b0, 3'd4, 8'd100, 8'hE2},
    {1'b0, 3'd5, 8'd150, 8'h6B},
    {1'b1, 3'd0, 8'd80,  8'h91},
    {1'b1, 3'd5, 8'd200, 8'h4D}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_buffer();
    @(negedge clk); mute = 1'b1;
    repeat (DEPTH + 2) @(posedge clk);
    @(negedge clk);
    check("R6 done before release", clear_done, 1'b1);
    check("R5 muted output", sample_out, 1'b0);
    mute = 1'b0;
    @(negedge clk);
  endtask

  task automatic stream(input bit slow, input int d, input int nstb,
                        input logic [7:0] seed);
    logic [7:0] lfsr = seed;
    int n = 0;
    logic prev = 1'b0;
    logic exp;
    for (int i = 0; i < nstb; i++) begin
      sample_stb = 1'b1;
      sample_in = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      @(posedge clk);
      @(negedge clk);
      sample_stb = 1'b0;
      if (slow && (i % 2 == 1)) begin
        check("R3 odd strobe ignored", sample_out, prev);
      end else begin
        hist[n] = sample_in;
        exp = (n >= d) ? hist[n - d] : 1'b0;
        if (n < d) check("R7 blank after clear", sample_out, exp);
        else if (n >= DEPTH) check("R8 wrapped delay", sample_out, exp);
        else if (slow) check("R3 slow delay", sample_out, exp);
        else check("R2 fast delay", sample_out, exp);
        prev = exp;
        n++;
      end
      @(negedge clk);
      check("R9 hold between strobes", sample_out, prev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", sample_out, 1'b0);
    check("R1 reset done flag", clear_done, 1'b0);
    rst = 1'b0;

    // R6: exact sweep length
    @(negedge clk); mute = 1'b1;
    repeat (DEPTH - 1) @(posedge clk);
    @(negedge clk);
    check("R6 not done at DEPTH-1", clear_done, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R6 done at DEPTH", clear_done, 1'b1);
    repeat (5) @(posedge clk); @(negedge clk);
    check("R6 done held", clear_done, 1'b1);
    mute = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 done drops", clear_done, 1'b0);

    // Table of rows
    for (int r = 0; r < 8; r++) begin
      logic [19:0] row = ROWS[r];
      delay_code = row[18:16];
      slow_mode = row[19];
      clear_buffer();
      stream(row[19], (int'(row[18:16]) + 1) * SPS, int'(row[15:8]), row[7:0]);
    end

    // R5: mute mid-stream with ones buffered
    delay_code = 3'd0; slow_mode = 1'b0;
    clear_buffer();
    for (int i = 0; i < 20; i++) begin
      sample_stb = 1'b1; sample_in = 1'b1;
      @(posedge clk); @(negedge clk);
      sample_stb = 1'b0;
      @(negedge clk);
    end
    check("R2 ones reach output", sample_out, 1'b1);
    mute = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R5 mute zeroes output", sample_out, 1'b0);
    sample_stb = 1'b1; sample_in = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_stb = 1'b0;
    check("R5 strobe under mute", sample_out, 1'b0);
    mute = 1'b0;
    @(negedge clk);

    // R4: reserved codes keep the step-2 delay
    @(negedge clk); mute = 1'b1;
    delay_code = 3'd1;
    @(negedge clk); delay_code = 3'b110;
    @(negedge clk); delay_code = 3'b111;
    repeat (DEPTH + 2) @(posedge clk);
    @(negedge clk);
    mute = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2 * SPS + 1; i++) begin
      sample_stb = 1'b1; sample_in = (i == 0);
      @(posedge clk); @(negedge clk);
      sample_stb = 1'b0;
      if (i == 2 * SPS - 1) check("R4 reserved code before edge", sample_out, 1'b0);
      if (i == 2 * SPS) check("R4 reserved code held delay", sample_out, 1'b1);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule